// File: doc/BRIEF.md
# Supply-Loss Sleep and Pad Override Controller

This block sits in the always-on clock domain of a chip and decides when the rest of the chip loses its clocks. It samples an external supply-health flag through a synchronizer. When software has armed the feature and the flag goes low, the block removes the clock enables of every domain except the real-time-clock domain. The same event forces a group of external memory-bus pads to high impedance and a group of output pads (the sample clock and the serial transmit lines) to a driven zero.

A discrete I/O pad can be given over to the block through a 3-bit configuration field. With that field set, the pad drives 1 while the chip sleeps, which asks an external RF front end to power down. This field survives the ordinary system reset and clears only on power-on reset. When the supply flag returns, the block waits a programmable number of always-on cycles before the clocks come back, so that the external synthesizer has time to lock. A sticky status bit records that a supply-loss sleep took place, and software clears it by writing 1.

Software reaches four registers through a write port and a read port. Address 0 holds the arm bit at bit 15. Address 1 holds the wake delay. Address 2 holds the discrete-pad field at bits [2:0]. Address 3 holds the status bit at bit 0.

Top module: `sleep_ctrl`

## Requirements
- R1: With the arm bit (address 0, bit 15) at 1, a low level on `pg_in` that is held makes every non-RTC clock enable fall exactly 4 clock cycles after the input changes. The enables stay high through the 3rd cycle.
- R2: With the arm bit at 0, a low `pg_in` has no effect: all clock enables stay high and the pads keep passing functional values.
- R3: The clock enable at index `RTC_IDX` is 1 at all times. All other enables are 0 whenever the chip is asleep or waking.
- R4: While the clocks are off (asleep or waking), every memory-bus pad has output enable 0 (high impedance) and output 0.
- R5: While the clocks are off, every forced-low pad has output 0 and output enable 1.
- R6: With the discrete-pad field equal to 3'b100, the discrete pad has output enable 1. Its output is 1 only while asleep; it is 0 while waking and while running.
- R7: With any other field value, and after reset, the discrete pad has output enable 0 (input).
- R8: The discrete-pad field is cleared only by `por`. Asserting `rst` leaves it unchanged, and writes made while `rst` is high are ignored.
- R9: After `pg_in` returns high, the clock enables come back exactly D+5 cycles later, where D is the wake delay at address 1. A new low on `pg_in` during the wait sends the block back to sleep.
- R10: Status bit 0 at address 3 is set when a sleep starts. It can be read while asleep and after wake-up. Writing 1 to it clears it, and a new sleep start wins over a clear in the same cycle.
- R11: Outside sleep and wake, the memory-bus and forced-low pads present the functional output and output-enable values one cycle later, unchanged.
- R12: A read returns its data one cycle after the address is applied. Reset values are: arm bit 0, wake delay `WAKE_RST`, status 0, discrete-pad field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Synchronous active-high power-on reset |
| pg_in | input | 1 | Asynchronous supply-good flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Registered read data |
| clk_en | output | NUM_DOM | Per-domain clock enables |
| fn_mem_o | input | N_MEM | Functional memory-bus pad outputs |
| fn_mem_oe | input | N_MEM | Functional memory-bus pad output enables |
| pad_mem_o | output | N_MEM | Memory-bus pad outputs after override |
| pad_mem_oe | output | N_MEM | Memory-bus pad output enables after override |
| fn_lo_o | input | N_LO | Functional forced-low pad outputs |
| fn_lo_oe | input | N_LO | Functional forced-low pad output enables |
| pad_lo_o | output | N_LO | Forced-low pad outputs after override |
| pad_lo_oe | output | N_LO | Forced-low pad output enables after override |
| pad_dio_o | output | 1 | Discrete pad output |
| pad_dio_oe | output | 1 | Discrete pad output enable |

## Verification
The assertions check on every cycle how the sleep state maps onto the pad and clock-enable outputs. They also check that an unarmed or still-waiting controller holds its state, that the status bit is set when a sleep begins, and that the pad field survives a system reset. Only the bench scenarios can show the exact 4-cycle entry latency and the D+5 wake latency as seen at the pins, the software view through the read port, and the clear-on-write of the status bit. They also cover the return to sleep from the wake wait and the one-cycle pass-through of random functional traffic.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } pstate_e;

  localparam int          REG_AW   = 2;
  localparam logic [1:0]  A_CTRL   = 2'd0;
  localparam logic [1:0]  A_WAKE   = 2'd1;
  localparam logic [1:0]  A_PADCFG = 2'd2;
  localparam logic [1:0]  A_STAT   = 2'd3;
  localparam int          ARM_BIT  = 15;
  localparam logic [2:0]  DIO_RFPD = 3'b100;
endpackage

// File: rtl/sleep_pg_sync.sv
module sleep_pg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sleep_regs.sv
module sleep_regs
  import sleep_pkg::*;
#(
  parameter int                DW       = 16,
  parameter int                WAKE_W   = 16,
  parameter logic [WAKE_W-1:0] WAKE_RST = WAKE_W'(160)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic              pfail_set,
  output logic [DW-1:0]     rd_data,
  output logic              pg_en,
  output logic [WAKE_W-1:0] wake_dly,
  output logic [2:0]        dio_cfg,
  output logic              pfail
);
  logic          rst_any;
  logic          wr_ok;
  logic [DW-1:0] rd_next;

  assign rst_any = rst | por;
  assign wr_ok   = wr_en & ~rst_any;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      pg_en    <= 1'b0;
      wake_dly <= WAKE_RST;
      pfail    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) pg_en    <= wr_data[ARM_BIT];
      if (wr_en && wr_addr == A_WAKE) wake_dly <= wr_data[WAKE_W-1:0];
      if (pfail_set)                  pfail    <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && wr_data[0]) pfail <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por)                               dio_cfg <= 3'b000;
    else if (wr_ok && wr_addr == A_PADCFG) dio_cfg <= wr_data[2:0];
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CTRL:   rd_next[ARM_BIT]     = pg_en;
      A_WAKE:   rd_next[WAKE_W-1:0]  = wake_dly;
      A_PADCFG: rd_next[2:0]         = dio_cfg;
      default:  rd_next[0]           = pfail;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) rd_data <= '0;
    else         rd_data <= rd_next;
  end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_en,
  input  logic              pg_ok,
  input  logic [WAKE_W-1:0] wake_dly,
  output pstate_e           st,
  output logic [WAKE_W-1:0] wake_cnt,
  output logic              entry
);
  assign entry = (st == ST_RUN) && pg_en && !pg_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RUN;
      wake_cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (entry) st <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (pg_ok) begin
            st       <= ST_WAKE;
            wake_cnt <= wake_dly;
          end
        end
        ST_WAKE: begin
          if (!pg_ok)               st <= ST_SLEEP;
          else if (wake_cnt == '0)  st <= ST_RUN;
          else                      wake_cnt <= wake_cnt - 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sleep_pads.sv
module sleep_pads
  import sleep_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int RTC_IDX = 0,
  parameter int N_MEM   = 7,
  parameter int N_LO    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  pstate_e            st,
  input  logic [2:0]         dio_cfg,
  input  logic [N_MEM-1:0]   fn_mem_o,
  input  logic [N_MEM-1:0]   fn_mem_oe,
  input  logic [N_LO-1:0]    fn_lo_o,
  input  logic [N_LO-1:0]    fn_lo_oe,
  output logic [NUM_DOM-1:0] clk_en,
  output logic [N_MEM-1:0]   pad_mem_o,
  output logic [N_MEM-1:0]   pad_mem_oe,
  output logic [N_LO-1:0]    pad_lo_o,
  output logic [N_LO-1:0]    pad_lo_oe,
  output logic               pad_dio_o,
  output logic               pad_dio_oe
);
  logic gated;
  logic rf_req;

  assign gated  = (st != ST_RUN);
  assign rf_req = (st == ST_SLEEP);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (d == RTC_IDX) begin : g_rtc
      always_ff @(posedge clk) clk_en[d] <= 1'b1;
    end else begin : g_gate
      always_ff @(posedge clk) begin
        if (rst) clk_en[d] <= 1'b1;
        else     clk_en[d] <= ~gated;
      end
    end
  end

  for (genvar m = 0; m < N_MEM; m++) begin : g_mem
    always_ff @(posedge clk) begin
      if (rst || gated) begin
        pad_mem_o[m]  <= 1'b0;
        pad_mem_oe[m] <= 1'b0;
      end else begin
        pad_mem_o[m]  <= fn_mem_o[m];
        pad_mem_oe[m] <= fn_mem_oe[m];
      end
    end
  end

  for (genvar k = 0; k < N_LO; k++) begin : g_lo
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_lo_o[k]  <= 1'b0;
        pad_lo_oe[k] <= 1'b0;
      end else if (gated) begin
        pad_lo_o[k]  <= 1'b0;
        pad_lo_oe[k] <= 1'b1;
      end else begin
        pad_lo_o[k]  <= fn_lo_o[k];
        pad_lo_oe[k] <= fn_lo_oe[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dio_cfg != DIO_RFPD) begin
      pad_dio_o  <= 1'b0;
      pad_dio_oe <= 1'b0;
    end else begin
      pad_dio_o  <= rf_req;
      pad_dio_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int                NUM_DOM  = 4,
  parameter int                RTC_IDX  = 0,
  parameter int                N_MEM    = 7,
  parameter int                N_LO     = 3,
  parameter int                DW       = 16,
  parameter int                WAKE_W   = 16,
  parameter logic [WAKE_W-1:0] WAKE_RST = WAKE_W'(160),
  parameter int                SYNC_N   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               por,
  input  logic               pg_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NUM_DOM-1:0] clk_en,
  input  logic [N_MEM-1:0]   fn_mem_o,
  input  logic [N_MEM-1:0]   fn_mem_oe,
  output logic [N_MEM-1:0]   pad_mem_o,
  output logic [N_MEM-1:0]   pad_mem_oe,
  input  logic [N_LO-1:0]    fn_lo_o,
  input  logic [N_LO-1:0]    fn_lo_oe,
  output logic [N_LO-1:0]    pad_lo_o,
  output logic [N_LO-1:0]    pad_lo_oe,
  output logic               pad_dio_o,
  output logic               pad_dio_oe
);
  logic              rst_any;
  logic              pg_ok;
  logic              pg_en;
  logic [WAKE_W-1:0] wake_dly;
  logic [WAKE_W-1:0] wake_cnt;
  logic [2:0]        dio_cfg;
  logic              pfail;
  logic              entry;
  pstate_e           st;

  assign rst_any = rst | por;

  sleep_pg_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst_any), .d_async(pg_in), .d_sync(pg_ok)
  );

  sleep_regs #(.DW(DW), .WAKE_W(WAKE_W), .WAKE_RST(WAKE_RST)) u_regs (
    .clk(clk), .rst(rst), .por(por),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pfail_set(entry), .rd_data(rd_data),
    .pg_en(pg_en), .wake_dly(wake_dly), .dio_cfg(dio_cfg), .pfail(pfail)
  );

  sleep_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk(clk), .rst(rst_any), .pg_en(pg_en), .pg_ok(pg_ok),
    .wake_dly(wake_dly), .st(st), .wake_cnt(wake_cnt), .entry(entry)
  );

  sleep_pads #(.NUM_DOM(NUM_DOM), .RTC_IDX(RTC_IDX), .N_MEM(N_MEM), .N_LO(N_LO)) u_pads (
    .clk(clk), .rst(rst_any), .st(st), .dio_cfg(dio_cfg),
    .fn_mem_o(fn_mem_o), .fn_mem_oe(fn_mem_oe),
    .fn_lo_o(fn_lo_o), .fn_lo_oe(fn_lo_oe),
    .clk_en(clk_en),
    .pad_mem_o(pad_mem_o), .pad_mem_oe(pad_mem_oe),
    .pad_lo_o(pad_lo_o), .pad_lo_oe(pad_lo_oe),
    .pad_dio_o(pad_dio_o), .pad_dio_oe(pad_dio_oe)
  );
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk
  import sleep_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int RTC_IDX = 0,
  parameter int N_MEM   = 7,
  parameter int N_LO    = 3,
  parameter int WAKE_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               por,
  input pstate_e            st,
  input logic               pg_ok,
  input logic               pg_en,
  input logic [2:0]         dio_cfg,
  input logic               pfail,
  input logic [WAKE_W-1:0]  wake_cnt,
  input logic [NUM_DOM-1:0] clk_en,
  input logic [N_MEM-1:0]   pad_mem_oe,
  input logic [N_LO-1:0]    pad_lo_o,
  input logic [N_LO-1:0]    pad_lo_oe,
  input logic               pad_dio_o,
  input logic               pad_dio_oe
);
  localparam logic [NUM_DOM-1:0] RTC_MASK = NUM_DOM'(1) << RTC_IDX;

  AST_ARMED_ENTRY: assert property (@(posedge clk) disable iff (rst || por)
    (st == ST_RUN && pg_en && !pg_ok) |=> (st == ST_SLEEP)); // R1
  AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (rst || por)
    (st == ST_RUN && !pg_en) |=> (st == ST_RUN)); // R2
  AST_RTC_ALIVE: assert property (@(posedge clk) disable iff (rst || por)
    clk_en[RTC_IDX]); // R3
  AST_CORE_GATED: assert property (@(posedge clk) disable iff (rst || por)
    (st != ST_RUN) |=> ((clk_en & ~RTC_MASK) == '0)); // R3
  AST_MEM_HIZ: assert property (@(posedge clk) disable iff (rst || por)
    (st != ST_RUN) |=> (pad_mem_oe == '0)); // R4
  AST_LO_FORCED: assert property (@(posedge clk) disable iff (rst || por)
    (st != ST_RUN) |=> (pad_lo_o == '0 && pad_lo_oe == '1)); // R5
  AST_RF_REQ: assert property (@(posedge clk) disable iff (rst || por)
    (st == ST_SLEEP && dio_cfg == DIO_RFPD) |=> (pad_dio_oe && pad_dio_o)); // R6
  AST_DIO_INPUT: assert property (@(posedge clk) disable iff (rst || por)
    (dio_cfg != DIO_RFPD) |=> !pad_dio_oe); // R7
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (por)
    (rst && !por) |=> $stable(dio_cfg)); // R8
  AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (rst || por)
    (st == ST_WAKE && wake_cnt != '0 && pg_ok) |=> (st == ST_WAKE)); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst || por)
    (st == ST_RUN && pg_en && !pg_ok) |=> pfail); // R10
endmodule

bind sleep_ctrl sleep_ctrl_chk #(
  .NUM_DOM(NUM_DOM), .RTC_IDX(RTC_IDX), .N_MEM(N_MEM), .N_LO(N_LO), .WAKE_W(WAKE_W)
) u_chk (
  .clk(clk), .rst(rst), .por(por), .st(st), .pg_ok(pg_ok), .pg_en(pg_en),
  .dio_cfg(dio_cfg), .pfail(pfail), .wake_cnt(wake_cnt), .clk_en(clk_en),
  .pad_mem_oe(pad_mem_oe), .pad_lo_o(pad_lo_o), .pad_lo_oe(pad_lo_oe),
  .pad_dio_o(pad_dio_o), .pad_dio_oe(pad_dio_oe)
);

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
  localparam int NUM_DOM = 4;
  localparam int RTC_IDX = 0;
  localparam int N_MEM   = 7;
  localparam int N_LO    = 3;
  localparam int DW      = 16;
  localparam logic [NUM_DOM-1:0] ALL_ON  = '1;
  localparam logic [NUM_DOM-1:0] RTC_ONLY = NUM_DOM'(1) << RTC_IDX;

  logic clk = 1'b0;
  logic rst = 1'b1, por = 1'b1, pg_in = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NUM_DOM-1:0] clk_en;
  logic [N_MEM-1:0] fn_mem_o = '0, fn_mem_oe = '0, pad_mem_o, pad_mem_oe;
  logic [N_LO-1:0]  fn_lo_o = '0, fn_lo_oe = '0, pad_lo_o, pad_lo_oe;
  logic pad_dio_o, pad_dio_oe;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sleep_ctrl i_sleep_ctrl (
    .clk(clk), .rst(rst), .por(por), .pg_in(pg_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_en(clk_en),
    .fn_mem_o(fn_mem_o), .fn_mem_oe(fn_mem_oe),
    .pad_mem_o(pad_mem_o), .pad_mem_oe(pad_mem_oe),
    .fn_lo_o(fn_lo_o), .fn_lo_oe(fn_lo_oe),
    .pad_lo_o(pad_lo_o), .pad_lo_oe(pad_lo_oe),
    .pad_dio_o(pad_dio_o), .pad_dio_oe(pad_dio_oe)
  );

  function automatic logic [NUM_DOM-1:0] exp_clk(input bit asleep);
    return asleep ? RTC_ONLY : ALL_ON;
  endfunction

  function automatic logic [1:0] exp_dio(input logic [2:0] cfg, input bit sleeping);
    return (cfg == 3'b100) ? {1'b1, sleeping} : 2'b00;  // {oe, o}
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    step();
    d = rd_data;
  endtask

  task automatic rand_fn();
    fn_mem_o = N_MEM'($urandom); fn_mem_oe = N_MEM'($urandom);
    fn_lo_o  = N_LO'($urandom);  fn_lo_oe  = N_LO'($urandom);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // measure cycles from pg_in rising to clocks back; mid-wait pad checks
  task automatic wake_measure(input int dly, input logic [2:0] cfg);
    int n = 0;
    pg_in = 1'b1;
    while (clk_en !== ALL_ON && n < dly + 60) begin
      step();
      n++;
      if (n == 4) begin
        chk("R6 dio during wake", exp_dio(cfg, 1'b0), {pad_dio_oe, pad_dio_o});
        chk("R4 mem hiz during wake", pad_mem_oe, '0);
      end
    end
    chk("R9 wake latency", n, dly + 5);
  endtask

  task automatic fail_cycle(input int dly, input bit arm, input logic [2:0] cfg);
    logic [DW-1:0] d;
    wr(2'd1, DW'(dly));
    wr(2'd2, {13'd0, cfg});
    wr(2'd0, {arm, 15'd0});
    rand_fn();
    pg_in = 1'b0;
    repeat (3) step();
    chk("R1 clocks still on at cycle 3", clk_en, ALL_ON);
    step();
    if (arm) begin
      chk("R1 clocks off at cycle 4", clk_en, exp_clk(1'b1));
      chk("R4 mem oe", pad_mem_oe, '0);
      chk("R4 mem o", pad_mem_o, '0);
      chk("R5 lo pads", {pad_lo_oe, pad_lo_o}, {{N_LO{1'b1}}, {N_LO{1'b0}}});
      chk("R6/R7 dio asleep", {pad_dio_oe, pad_dio_o}, exp_dio(cfg, 1'b1));
      rd(2'd3, d);
      chk("R10 flag readable asleep", d[0], 1'b1);
      wake_measure(dly, cfg);
      step();
      chk("R6/R7 dio running", {pad_dio_oe, pad_dio_o}, exp_dio(cfg, 1'b0));
      rd(2'd3, d);
      chk("R10 flag after wake", d[0], 1'b1);
      wr(2'd3, 16'h0001);
      rd(2'd3, d);
      chk("R10 flag cleared", d[0], 1'b0);
    end else begin
      repeat (10) step();
      chk("R2 unarmed clocks", clk_en, ALL_ON);
      chk("R2 unarmed pass-through", {pad_mem_oe, pad_mem_o}, {fn_mem_oe, fn_mem_o});
      rd(2'd3, d);
      chk("R2 no flag when unarmed", d[0], 1'b0);
      pg_in = 1'b1;
      repeat (4) step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'h5EED));
    repeat (3) step();
    rst = 1'b0; por = 1'b0;
    step();
    chk("R3 reset clocks", clk_en, ALL_ON);
    chk("R7 reset dio input", pad_dio_oe, 1'b0);
    rd(2'd0, d); chk("R12 reset arm", d, 16'h0000);
    rd(2'd1, d); chk("R12 reset wake delay", d, 16'd160);
    rd(2'd2, d); chk("R12 reset pad cfg", d, 16'h0000);
    rd(2'd3, d); chk("R12 reset status", d, 16'h0000);

    for (int i = 0; i < 120; i++) begin
      rand_fn();
      step();
      chk("R11 mem pass-through", {pad_mem_oe, pad_mem_o}, {fn_mem_oe, fn_mem_o});
      chk("R11 lo pass-through", {pad_lo_oe, pad_lo_o}, {fn_lo_oe, fn_lo_o});
    end

    fail_cycle(0, 1'b0, 3'b100);          // R2 unarmed
    fail_cycle(7, 1'b1, 3'b100);          // R1 R6 R9 R10
    fail_cycle(0, 1'b1, 3'b100);          // R9 zero delay
    fail_cycle(3, 1'b1, 3'b010);          // R7 other cfg

    // R9 relapse during the wake wait
    wr(2'd1, 16'd20);
    wr(2'd2, 16'd4);
    wr(2'd0, 16'h8000);
    pg_in = 1'b0;
    repeat (5) step();
    pg_in = 1'b1;
    repeat (6) step();
    pg_in = 1'b0;
    repeat (5) step();
    chk("R9 relapse clocks off", clk_en, exp_clk(1'b1));
    chk("R9 relapse rf request", {pad_dio_oe, pad_dio_o}, 2'b11);
    wake_measure(20, 3'b100);
    wr(2'd3, 16'h0001);

    // R8: system reset keeps the pad field, power-on reset clears it
    rst = 1'b1;
    step();
    wr(2'd2, 16'h0000);
    rst = 1'b0;
    step();
    rd(2'd2, d); chk("R8 cfg survives rst", d[2:0], 3'b100);
    rd(2'd0, d); chk("R12 arm cleared by rst", d, 16'h0000);
    step();
    chk("R6 dio driven low when running", {pad_dio_oe, pad_dio_o}, 2'b10);
    por = 1'b1;
    step();
    por = 1'b0;
    step();
    rd(2'd2, d); chk("R8 cfg cleared by por", d[2:0], 3'b000);
    chk("R7 dio input after por", pad_dio_oe, 1'b0);

    for (int i = 0; i < 8; i++) begin
      int unsigned dly = $urandom_range(0, 12);
      bit arm = 1'($urandom_range(0, 1));
      logic [2:0] cfg = ($urandom_range(0, 1) == 1) ? 3'b100 : 3'($urandom_range(0, 3));
      fail_cycle(int'(dly), arm, cfg);
    end

    summary();
    $finish;
  end
endmodule